// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Out

This block is a purely combinational 32-bit shifter. The amount of shift comes from a register operand. It performs a logical left shift, a logical right shift, an arithmetic right shift or a right rotation of its data input. It returns the shifted word, the bit that was last shifted out, and a strobe that tells the status logic whether that bit should replace the stored carry flag.

The amount is taken from the low byte of the operand, so every amount from 0 to 255 is legal. Amounts of zero, exactly the word width, and above the word width each follow their own result and carry rules. When the flag-setting mode is off, the same results are produced but no carry update is requested.

Top module: `regshift_carry`

## Requirements
- R1: Only bits 7..0 of `amt_in` set the shift amount. Bits 31..8 have no effect on `y`, `c_out` or `c_upd`.
- R2: The shift type is encoded on `kind`: 2'b00 is logical left, 2'b01 is logical right, 2'b10 is arithmetic right, 2'b11 is rotate right.
- R3: An amount of 0 passes `a_in` to `y` unchanged for every `kind`, with `c_upd` = 0 and `c_out` = 0.
- R4: For a logical left shift by n, 1 <= n <= 31, `y` is `a_in << n` and the carry is `a_in[32-n]`. For n = 32, `y` is 0 and the carry is `a_in[0]`. For n > 32, `y` is 0 and the carry is 0.
- R5: For a logical right shift by n, 1 <= n <= 31, `y` is `a_in >> n` and the carry is `a_in[n-1]`. For n = 32, `y` is 0 and the carry is `a_in[31]`. For n > 32, `y` is 0 and the carry is 0.
- R6: For an arithmetic right shift by n, 1 <= n <= 31, the sign bit fills the vacated positions and the carry is `a_in[n-1]`. For n >= 32, `y` is 32 copies of `a_in[31]` and the carry is `a_in[31]`.
- R7: A rotate right uses e = n mod 32. If e = 0 and n != 0, `y` equals `a_in` and the carry is `a_in[31]`. Otherwise `y` is `a_in` rotated right by e and the carry is `a_in[e-1]`.
- R8: With `flags_on` = 1 and a nonzero amount, `c_upd` = 1 and `c_out` carries the rule of R4 to R7.
- R9: With `flags_on` = 0, `y` follows R3 to R7 unchanged, and both `c_upd` and `c_out` are 0. As a consequence, a logical shift of 32 or more gives 0, and an arithmetic shift of 32 or more acts as a shift by 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | Data word to shift |
| amt_in | input | 32 | Amount operand; only its low byte is used |
| kind | input | 2 | Shift type select |
| flags_on | input | 1 | Flag-setting mode |
| y | output | 32 | Shifted result |
| c_out | output | 1 | Last bit shifted out (0 when no update) |
| c_upd | output | 1 | Carry flag must be written with c_out |

## Verification
Every result of this block is due in the same cycle its inputs change, because no register lies between the inputs and `y`, `c_out` or `c_upd`. The bench therefore drives a new operand set on the rising clock edge and compares all three outputs on the following falling edge, after the combinational path has settled. Each check also confirms that nothing from the previous vector leaks into the result.

// File: rtl/regshift_carry.sv
module regshift_carry #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] amt_in,
  input  logic [1:0]   kind,
  input  logic         flags_on,
  output logic [W-1:0] y,
  output logic         c_out,
  output logic         c_upd
);
  localparam int LW = $clog2(W);

  logic [AW-1:0]       n;
  logic [LW-1:0]       e;
  logic [LW:0]         n_clamp;
  logic [W:0]          ext_l;
  logic [W:0]          ext_r;
  logic signed [W:0]   ext_a_src;
  logic signed [W:0]   ext_a;
  logic [W-1:0]        rot;
  logic [W-1:0]        res;
  logic                cy;
  logic                unused_hi;

  assign n         = amt_in[AW-1:0];
  assign unused_hi = ^amt_in[W-1:AW];
  assign e         = n[LW-1:0];

  assign ext_l     = {1'b0, a_in} << n;
  assign ext_r     = {a_in, 1'b0} >> n;
  assign n_clamp   = (n >= AW'(W)) ? (LW+1)'(W) : n[LW:0];
  assign ext_a_src = {a_in, 1'b0};
  assign ext_a     = ext_a_src >>> n_clamp;
  assign rot       = (a_in >> e) | (a_in << (W - int'(e)));

  always_comb begin
    case (kind)
      2'b00:   begin res = ext_l[W-1:0]; cy = ext_l[W];   end
      2'b01:   begin res = ext_r[W:1];   cy = ext_r[0];   end
      2'b10:   begin res = ext_a[W:1];   cy = ext_a[0];   end
      default: begin res = rot;          cy = rot[W-1];   end
    endcase
  end

  assign y     = (n == '0) ? a_in : res;
  assign c_upd = flags_on && (n != '0);
  assign c_out = c_upd & cy;

  always_comb begin
    if (!$isunknown({a_in, amt_in, kind, flags_on})) begin
      a_r3_zero_pass: assert (n != '0 || (y == a_in && !c_upd && !c_out))
        else $error("R3 zero amount altered data or carry");
      a_r9_no_flags: assert (flags_on || (!c_upd && !c_out))
        else $error("R9 carry requested without flags");
      a_r8_upd_when_nonzero: assert (!(flags_on && n != '0) || c_upd)
        else $error("R8 missing carry update");
      a_r4_lsl_far: assert (!(kind == 2'b00 && n > AW'(W)) || (y == '0 && !c_out))
        else $error("R4 far left shift not cleared");
      a_r5_lsr_far: assert (!(kind == 2'b01 && n > AW'(W)) || (y == '0 && !c_out))
        else $error("R5 far right shift not cleared");
      a_r6_asr_fill: assert (!(kind == 2'b10 && n >= AW'(W)) || y == {W{a_in[W-1]}})
        else $error("R6 arithmetic fill wrong");
      a_r7_ror_carry: assert (!(kind == 2'b11 && c_upd) || c_out == y[W-1])
        else $error("R7 rotate carry differs from result msb");
    end
  end
endmodule

// File: tb/regshift_carry_test.sv
module regshift_carry_test;
  logic        clk = 1'b0;
  logic [31:0] a_in = '0;
  logic [31:0] amt_in = '0;
  logic [1:0]  kind = '0;
  logic        flags_on = 1'b0;
  logic [31:0] y;
  logic        c_out, c_upd;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  regshift_carry uut (
    .a_in(a_in), .amt_in(amt_in), .kind(kind), .flags_on(flags_on),
    .y(y), .c_out(c_out), .c_upd(c_upd)
  );

  task automatic vec(input string req, input logic [31:0] d, input logic [31:0] a,
                     input logic [1:0] k, input logic f,
                     input logic [31:0] ey, input logic eu, input logic ec);
    @(posedge clk);
    a_in = d; amt_in = a; kind = k; flags_on = f;
    @(negedge clk);
    checks++;
    if (y !== ey || c_upd !== eu || c_out !== ec) begin
      errors++;
      $display("FAIL %s: y=%h upd=%b c=%b expected y=%h upd=%b c=%b",
               req, y, c_upd, c_out, ey, eu, ec);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    checks++;
    if (y !== 32'h0 || c_upd !== 1'b0 || c_out !== 1'b0) begin
      errors++;
      $display("FAIL R3 idle: y=%h upd=%b c=%b expected y=0 upd=0 c=0", y, c_upd, c_out);
    end
  endtask

  task automatic t_zero_all_kinds();
    for (int k = 0; k < 4; k++)
      vec("R3", 32'h1234_5678, 32'h0, 2'(k), 1'b1, 32'h1234_5678, 1'b0, 1'b0);
  endtask

  task automatic t_lsl();
    vec("R4", 32'h8000_0001, 32'd1,  2'b00, 1'b1, 32'h0000_0002, 1'b1, 1'b1);
    vec("R4", 32'h8000_0001, 32'd31, 2'b00, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
    vec("R4", 32'h8000_0001, 32'd32, 2'b00, 1'b1, 32'h0,         1'b1, 1'b1);
    vec("R4", 32'h8000_0001, 32'd33, 2'b00, 1'b1, 32'h0,         1'b1, 1'b0);
  endtask

  task automatic t_lsr();
    vec("R5", 32'hF000_000F, 32'd4,   2'b01, 1'b1, 32'h0F00_0000, 1'b1, 1'b1);
    vec("R5", 32'hF000_000F, 32'd32,  2'b01, 1'b1, 32'h0,         1'b1, 1'b1);
    vec("R5", 32'hF000_000F, 32'd200, 2'b01, 1'b1, 32'h0,         1'b1, 1'b0);
  endtask

  task automatic t_asr();
    vec("R6", 32'h8000_0010, 32'd4,   2'b10, 1'b1, 32'hF800_0001, 1'b1, 1'b0);
    vec("R6", 32'h8000_0010, 32'd5,   2'b10, 1'b1, 32'hFC00_0000, 1'b1, 1'b1);
    vec("R6", 32'h8000_0010, 32'd255, 2'b10, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1);
    vec("R6", 32'h7000_0000, 32'd40,  2'b10, 1'b1, 32'h0,         1'b1, 1'b0);
  endtask

  task automatic t_ror();
    vec("R7", 32'h8000_0001, 32'd1,    2'b11, 1'b1, 32'hC000_0000, 1'b1, 1'b1);
    vec("R7", 32'h8000_0001, 32'd32,   2'b11, 1'b1, 32'h8000_0001, 1'b1, 1'b1);
    vec("R7", 32'h8000_0001, 32'h24,   2'b11, 1'b1, 32'h1800_0000, 1'b1, 1'b0);
    vec("R7", 32'h0000_0002, 32'h40,   2'b11, 1'b1, 32'h0000_0002, 1'b1, 1'b0);
  endtask

  task automatic t_upper_bits();
    vec("R1", 32'hF000_000F, 32'hFFFF_FF04, 2'b01, 1'b1, 32'h0F00_0000, 1'b1, 1'b1);
    vec("R1", 32'h8000_0001, 32'h0000_0100, 2'b00, 1'b1, 32'h8000_0001, 1'b0, 1'b0);
  endtask

  task automatic t_kind_code();
    vec("R2", 32'h0000_00F0, 32'd4, 2'b00, 1'b1, 32'h0000_0F00, 1'b1, 1'b0);
    vec("R2", 32'h0000_00F0, 32'd4, 2'b01, 1'b1, 32'h0000_000F, 1'b1, 1'b0);
    vec("R2", 32'h8000_00F0, 32'd4, 2'b10, 1'b1, 32'hF800_000F, 1'b1, 1'b0);
    vec("R2", 32'h0000_00F8, 32'd4, 2'b11, 1'b1, 32'h8000_000F, 1'b1, 1'b1);
  endtask

  task automatic t_no_flags();
    vec("R9", 32'h8000_0001, 32'd40,  2'b00, 1'b0, 32'h0,         1'b0, 1'b0);
    vec("R9", 32'h8000_0000, 32'd100, 2'b10, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    vec("R9", 32'h8000_0001, 32'd1,   2'b11, 1'b0, 32'hC000_0000, 1'b0, 1'b0);
    vec("R8", 32'h8000_0001, 32'd1,   2'b11, 1'b1, 32'hC000_0000, 1'b1, 1'b1);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_zero_all_kinds();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_upper_bits();
    t_kind_code();
    t_no_flags();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule